// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block holds the modem status byte of a serial port. It watches four active-low handshake pins from a modem: carrier detect, ring indicator, data set ready and clear to send. The upper nibble of the byte shows the asserted state of each line, which is the inverse of the pin. The lower nibble holds sticky flags that record a change on each line since the host last looked. A host read clears the flags, and a change that lands on the same cycle as the read is kept. The block also raises a modem-status interrupt request while any flag is set, when the request is enabled.

For self-test, a loopback mode takes the line states from four modem-control outputs instead of the external pins. Toggling those control bits then moves the status bits and sets the change flags. The external pins pass through a synchronizer before use. The loopback bits come from the same clock domain and are used directly.

Top module: `modem_status_reg`

## Requirements
- R1: Outside loopback, rd_data bit 7 is the inverse of dcd_n, bit 6 the inverse of ri_n, bit 5 the inverse of dsr_n and bit 4 the inverse of cts_n.
- R2: With loop_en high, rd_data bits 7, 6, 5 and 4 follow ctl_out2, ctl_out1, ctl_dtr and ctl_rts respectively.
- R3: Flag bits 3, 1 and 0 become 1 when status bit 7, 5 or 4 respectively changes in either direction.
- R4: Flag bit 2 becomes 1 only when status bit 6 goes from 1 to 0, which is ri_n rising at the end of a ring. A 0-to-1 change of bit 6 leaves it unchanged.
- R5: A set flag stays set until a cycle with rd_stb high, and that read clears it on the following clock edge. The read returns the value present before the clear.
- R6: A change that is detected on the clock edge that ends a read leaves its flag set.
- R7: In loopback, the flags are computed from the control bits, and activity on the external pins has no effect on rd_data.
- R8: irq is registered. One cycle after any flag is set and irq_en is high, irq is 1. It is 0 when irq_en is low or no flag is set.
- R9: During reset all flags and irq are 0, and the status bits load the present line levels, so releasing reset sets no flag.
- R10: A pin change shows in rd_data on the third rising edge after it. A control-bit or loop_en change in loopback shows on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Data set ready pin, active low, asynchronous |
| cts_n | input | 1 | Clear to send pin, active low, asynchronous |
| loop_en | input | 1 | Loopback select |
| ctl_out2 | input | 1 | Modem-control auxiliary output 2, looped to bit 7 |
| ctl_out1 | input | 1 | Modem-control auxiliary output 1, looped to bit 6 |
| ctl_dtr | input | 1 | Modem-control terminal-ready bit, looped to bit 5 |
| ctl_rts | input | 1 | Modem-control request-to-send bit, looped to bit 4 |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status nibble in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The properties assume that loop_en, the control bits, rd_stb and irq_en are synchronous to clk, as register outputs in the same domain would be. They also assume that reset is held long enough for the synchronizer to fill. Past-value checks are therefore suspended for one cycle after reset ends. The bench drives every input on the falling edge and holds reset for four cycles with steady pins. It keeps each pin level for at least three cycles, so every change crosses the synchronizer before the next one arrives.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;
  // number of modem handshake lines; status byte is twice this wide
  localparam int unsigned MSR_LINES = 4;
  typedef logic [MSR_LINES-1:0] line_vec_t;
  // line order inside a nibble: 3 carrier, 2 ring, 1 set ready, 0 clear to send
  // ring flag fires only on the asserted-to-idle transition of its status bit
  localparam line_vec_t RING_FALL_MASK = 4'b0100;
endpackage

// File: rtl/msr_sync.sv
`timescale 1ns/1ps
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stg[s] <= stg[s-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
`timescale 1ns/1ps
module msr_src_sel #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             loop_en,
  input  logic [WIDTH-1:0] pin_n,
  input  logic [WIDTH-1:0] loop_bits,
  output logic [WIDTH-1:0] lvl
);
  // pins are active low; control bits are already active high
  always_comb lvl = loop_en ? loop_bits : ~pin_n;
endmodule

// File: rtl/msr_delta.sv
`timescale 1ns/1ps
module msr_delta #(
  parameter int unsigned       WIDTH     = 4,
  parameter logic [WIDTH-1:0]  FALL_ONLY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_d,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] flag_d
);
  logic [WIDTH-1:0] hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    if (FALL_ONLY[i]) begin : g_fall
      assign hit[i] = lvl_q[i] & ~lvl_d[i];
    end else begin : g_any
      assign hit[i] = lvl_q[i] ^ lvl_d[i];
    end
  end

  // new events win over a simultaneous read-clear
  always_comb flag_d = (rd_clr ? '0 : flag_q) | hit;

  // level register tracks the source even in reset, so release is quiet
  always_ff @(posedge clk) begin
    lvl_q <= lvl_d;
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/modem_status_reg.sv
`timescale 1ns/1ps
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dcd_n,
  input  logic       ri_n,
  input  logic       dsr_n,
  input  logic       cts_n,
  input  logic       loop_en,
  input  logic       ctl_out2,
  input  logic       ctl_out1,
  input  logic       ctl_dtr,
  input  logic       ctl_rts,
  input  logic       rd_stb,
  input  logic       irq_en,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int unsigned W = MSR_LINES;

  line_vec_t pin_n, pin_sync_n, loop_bits, lvl_d, lvl_q, flag_q, flag_d;
  logic      irq_q;

  assign pin_n     = {dcd_n, ri_n, dsr_n, cts_n};
  assign loop_bits = {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};

  msr_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_n),
    .q   (pin_sync_n)
  );

  msr_src_sel #(.WIDTH(W)) u_sel (
    .loop_en   (loop_en),
    .pin_n     (pin_sync_n),
    .loop_bits (loop_bits),
    .lvl       (lvl_d)
  );

  msr_delta #(.WIDTH(W), .FALL_ONLY(RING_FALL_MASK)) u_delta (
    .clk    (clk),
    .rst    (rst),
    .lvl_d  (lvl_d),
    .rd_clr (rd_stb),
    .lvl_q  (lvl_q),
    .flag_q (flag_q),
    .flag_d (flag_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_en & (|flag_d);
  end

  assign rd_data = {lvl_q, flag_q};
  assign irq     = irq_q;
endmodule

// File: rtl/modem_status_reg_chk.sv
`timescale 1ns/1ps
module modem_status_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_stb,
  input logic       irq_en,
  input logic       loop_en,
  input logic [3:0] loop_bits,
  input logic [7:0] rd_data,
  input logic       irq
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (rd_data[3:0] == 4'h0) && !irq);

  // R2
  loop_level_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    loop_en |=> rd_data[7:4] == $past(loop_bits));

  // R3
  cts_flag_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(rd_data[4]) |-> rd_data[0]);

  // R3
  dcd_flag_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(rd_data[7]) |-> rd_data[3]);

  // R4
  ring_dir_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    $rose(rd_data[2]) |-> $fell(rd_data[6]));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    1'b1 |=> (irq == ($past(irq_en) && (|rd_data[3:0]))));
endmodule

bind modem_status_reg modem_status_reg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_stb    (rd_stb),
  .irq_en    (irq_en),
  .loop_en   (loop_en),
  .loop_bits ({ctl_out2, ctl_out1, ctl_dtr, ctl_rts}),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/modem_status_reg_tb.sv
`timescale 1ns/1ps
module modem_status_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dcd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
  logic loop_en = 1'b0;
  logic ctl_out2 = 1'b0, ctl_out1 = 1'b0, ctl_dtr = 1'b0, ctl_rts = 1'b0;
  logic rd_stb = 1'b0;
  logic irq_en = 1'b0;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  modem_status_reg u_dut (
    .clk(clk), .rst(rst), .dcd_n(dcd_n), .ri_n(ri_n), .dsr_n(dsr_n),
    .cts_n(cts_n), .loop_en(loop_en), .ctl_out2(ctl_out2),
    .ctl_out1(ctl_out1), .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
    .rd_stb(rd_stb), .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: queue the expected byte, strobe a read for one cycle
  task automatic do_read(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
  endtask

  // monitor: compare the byte seen during each read strobe
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_stb) begin
        if (exp_q.size() == 0) begin
          check("scoreboard", 8'h01, 8'h00);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    check("R9 reset value", rd_data, 8'h00);
    check("R9 reset irq", {7'd0, irq}, 8'h00);

    // clear to send asserted: latency, then level and flag
    cts_n = 1'b0;
    tick(2);
    check("R10 not yet visible", rd_data, 8'h00);
    tick(1);
    check("R8 irq gated off", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;
    tick(1);
    check("R8 irq raised", {7'd0, irq}, 8'h01);
    do_read(8'h11, "R1 R3 R10 cts asserted");
    check("R8 irq after read", {7'd0, irq}, 8'h00);
    do_read(8'h10, "R5 cleared by read");

    cts_n = 1'b1;
    tick(3);
    do_read(8'h01, "R3 cts released");
    do_read(8'h00, "R5 cleared");

    // ring: start of ring no flag, end of ring flag
    ri_n = 1'b0;
    tick(3);
    do_read(8'h40, "R1 R4 ring start no flag");
    ri_n = 1'b1;
    tick(3);
    do_read(8'h04, "R4 ring end flag");
    do_read(8'h00, "R5 ring flag cleared");

    // carrier and set ready together
    dcd_n = 1'b0; dsr_n = 1'b0;
    tick(3);
    do_read(8'hAA, "R1 R3 dcd dsr asserted");
    do_read(8'hA0, "R5 cleared");
    dcd_n = 1'b1; dsr_n = 1'b1;
    tick(3);
    do_read(8'h0A, "R3 dcd dsr released");
    do_read(8'h00, "R5 cleared");

    // flag stays set across a pulse with no read
    cts_n = 1'b0;
    tick(3);
    cts_n = 1'b1;
    tick(3);
    do_read(8'h01, "R5 sticky across pulse");
    do_read(8'h00, "R5 cleared");

    // change lands on the clearing edge of a read
    cts_n = 1'b0;
    tick(2);
    do_read(8'h00, "R6 read before change");
    do_read(8'h11, "R6 flag kept");
    cts_n = 1'b1;
    tick(3);
    do_read(8'h01, "R3 release");
    do_read(8'h00, "R5 cleared");

    // loopback
    loop_en = 1'b1;
    tick(1);
    ctl_out2 = 1'b1;
    tick(1);
    do_read(8'h88, "R2 R7 R10 out2 loop");
    do_read(8'h80, "R5 cleared");
    ctl_out1 = 1'b1;
    tick(1);
    do_read(8'hC0, "R2 R4 out1 rise no flag");
    ctl_out1 = 1'b0;
    tick(1);
    do_read(8'h84, "R4 R7 out1 fall flag");
    ctl_dtr = 1'b1;
    tick(1);
    do_read(8'hA2, "R2 R7 dtr loop");
    ctl_rts = 1'b1;
    tick(1);
    do_read(8'hB1, "R2 R7 rts loop");
    cts_n = 1'b0;
    tick(3);
    do_read(8'hB0, "R7 pin ignored in loop");
    loop_en = 1'b0;
    tick(1);
    do_read(8'h1A, "R1 R3 leave loopback");
    ctl_out2 = 1'b0; ctl_dtr = 1'b0; ctl_rts = 1'b0;
    do_read(8'h10, "R5 cleared");

    // reset with lines asserted: levels loaded, no flags
    dcd_n = 1'b0;
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
    check("R9 irq after reset", {7'd0, irq}, 8'h00);
    do_read(8'h90, "R9 levels captured no flag");

    tick(2);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    finish_run();
  end
endmodule